// File: doc/BRIEF.md
# Line-Activity Power Mode Controller

This block decides, once per clock, whether the line drivers, the receiver outputs and the supply generator of a multi-channel serial line interface are powered. Two control pins set the mode with strict priority. An active-low shutdown pin wins over everything. A hold-on pin keeps the interface awake no matter what the line does. When neither pin overrides, the block watches per-receiver "input inactive" flags and parks the drivers and the supply generator once the line has been quiet long enough.

The inactive flags come from analog comparators and arrive asynchronous to the clock. They pass through a flop synchroniser together with the two control pins. Three tick-based timers then work on the synchronised flags. The first filters a line-present STATUS output that is valid in every mode. The second measures quiet time before standby. The third delays the driver enable after activity returns, which gives the supply generator time to come up. All delays are parameters counted in clock ticks.

Top module: `line_power_ctrl`

## Requirements
- R1: Both control pins and every inactive flag pass through a SYNC_STAGES-flop synchroniser. A control pin change applied before clock edge 1 shows on the enables right after edge SYNC_STAGES+1, and not earlier.
- R2: While the synchronised shutdown pin `shdn_n_i` is low (0 = shut down), `drv_en_o`, `rx_en_o` and `pump_en_o` are all 0, whatever the hold pin or line activity.
- R3: With `shdn_n_i` high and `hold_on_i` high (1 = hold on), all three enables are 1, even when every receiver is inactive.
- R4: With `shdn_n_i` high and `hold_on_i` low (automatic mode), `rx_en_o` is 1 whether the line is idle or active.
- R5: In automatic mode, `pump_en_o` is 1 exactly while the block is not in standby, so the supply generator starts as soon as activity is seen.
- R6: In automatic mode, `drv_en_o` is 0 in standby. It becomes 1 only after the standby condition has been clear for WAKE_DLY consecutive clock edges. `drv_en_o` is never 1 while `pump_en_o` is 0.
- R7: `rx_idle_i[i]` = 1 means receiver i sees no valid signal. Standby is entered when all synchronised flags have been 1 for IDLE_DLY consecutive edges. Any flag at 0 clears standby at the next edge and restarts the count.
- R8: `status_o` is 1 when any receiver is active and 0 when all are inactive. It takes a new value only after the synchronised activity has disagreed with it for STATUS_DLY consecutive edges. Shorter disagreements leave it unchanged, and it keeps working during shutdown.
- R9: During and right after reset, all enables and `status_o` are 0 and the line is taken to be quiet. Automatic mode therefore begins in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timer ticks are cycles of this clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n_i | input | 1 | Asynchronous shutdown request, 0 = full shutdown |
| hold_on_i | input | 1 | Asynchronous hold-awake request, 1 = bypass automatic standby |
| rx_idle_i | input | N_RX | Per-receiver inactive flags from comparators, 1 = no signal |
| status_o | output | 1 | Filtered line-present indication |
| drv_en_o | output | 1 | Line driver enable (0 = drivers high impedance) |
| rx_en_o | output | 1 | Receiver output enable (0 = receiver outputs high impedance) |
| pump_en_o | output | 1 | Supply generator enable |

## Verification
The bench aims at the exact edge on which each timer fires. If a timer is off by one, `pump_en_o` drops one cycle early or late, or `drv_en_o` rises a cycle before the wake count is complete. It injects one-cycle activity pulses: a design that fails to restart the quiet count would enter standby on schedule, and a status filter that skips its persistence window would pass the pulse to `status_o`. Shutdown is applied while the line is active, which catches a design that freezes STATUS or lets the hold pin win over shutdown. Seeded random mode and activity sequences are compared cycle by cycle against a bench model of the requirements.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

   typedef enum logic [1:0] {
      LPC_OFF  = 2'd0,
      LPC_HOLD = 2'd1,
      LPC_AUTO = 2'd2
   } lpc_mode_e;

   // Counter width able to hold values 0 .. n-1 (at least one bit).
   function automatic int unsigned lpc_cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/lpc_sync.sv
// Multi-flop synchroniser for a bus of independent asynchronous bits.
module lpc_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/lpc_persist.sv
// Output follows the input only after the two have disagreed for DLY
// consecutive edges; a shorter disagreement is discarded.
module lpc_persist import lpc_pkg::*; #(
   parameter int unsigned DLY   = 4,
   parameter logic        RST_Q = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (DLY == 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= RST_Q;
         else        q <= d;
      end
   end else begin : g_count
      localparam int unsigned CW = lpc_cnt_w(DLY);
      localparam logic [CW-1:0] LAST = CW'(DLY - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q   <= RST_Q;
            cnt <= '0;
         end else if (d == q) begin
            cnt <= '0;
         end else if (cnt == LAST) begin
            q   <= d;
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/lpc_rise_timer.sv
// Output rises once the input has been high for DLY consecutive edges and
// falls on the first edge that samples the input low.
module lpc_rise_timer import lpc_pkg::*; #(
   parameter int unsigned DLY   = 4,
   parameter logic        RST_Q = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (DLY == 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= RST_Q;
         else        q <= d;
      end
   end else begin : g_count
      localparam int unsigned CW = lpc_cnt_w(DLY);
      localparam logic [CW-1:0] LAST = CW'(DLY - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q   <= RST_Q;
            cnt <= '0;
         end else if (!d) begin
            q   <= 1'b0;
            cnt <= '0;
         end else if (!q) begin
            if (cnt == LAST) q   <= 1'b1;
            else             cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/line_power_ctrl.sv
// Power mode controller for a multi-channel serial line interface.
module line_power_ctrl import lpc_pkg::*; #(
   parameter int unsigned N_RX        = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned STATUS_DLY  = 20,
   parameter int unsigned IDLE_DLY    = 100,
   parameter int unsigned WAKE_DLY    = 200
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            shdn_n_i,
   input  logic            hold_on_i,
   input  logic [N_RX-1:0] rx_idle_i,
   output logic            status_o,
   output logic            drv_en_o,
   output logic            rx_en_o,
   output logic            pump_en_o
);

   localparam int unsigned SW = N_RX + 2;
   localparam logic [SW-1:0] SYNC_RST = {2'b00, {N_RX{1'b1}}};

   // elaboration-time parameter checks
   if (N_RX < 1) begin : g_bad_nrx
      $error("line_power_ctrl: N_RX must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("line_power_ctrl: SYNC_STAGES must be at least 2");
   end
   if (STATUS_DLY < 1 || IDLE_DLY < 1 || WAKE_DLY < 1) begin : g_bad_dly
      $error("line_power_ctrl: every delay must be at least one tick");
   end

   // synchronise pins and flags together
   logic [SW-1:0]   raw_in;
   logic [SW-1:0]   synced;
   logic            shdn_s;
   logic            hold_s;
   logic [N_RX-1:0] idle_s;
   logic            act_s;

   assign raw_in = {shdn_n_i, hold_on_i, rx_idle_i};

   lpc_sync #(
      .W       (SW),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (synced)
   );

   assign shdn_s = synced[SW-1];
   assign hold_s = synced[SW-2];
   assign idle_s = synced[N_RX-1:0];
   assign act_s  = ~&idle_s;

   // filtered line-present indication, runs in every mode
   lpc_persist #(
      .DLY   (STATUS_DLY),
      .RST_Q (1'b0)
   ) u_status (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (act_s),
      .q     (status_o)
   );

   // accumulated quiet time; the line is taken as quiet out of reset
   logic idle_q;
   logic ready_q;

   lpc_rise_timer #(
      .DLY   (IDLE_DLY),
      .RST_Q (1'b1)
   ) u_idle (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (!act_s),
      .q     (idle_q)
   );

   // driver wake-up delay after standby clears
   lpc_rise_timer #(
      .DLY   (WAKE_DLY),
      .RST_Q (1'b0)
   ) u_wake (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (!idle_q),
      .q     (ready_q)
   );

   // mode selection with strict pin priority
   lpc_mode_e mode_q;
   lpc_mode_e mode_d;

   always_comb begin
      if (!shdn_s)     mode_d = LPC_OFF;
      else if (hold_s) mode_d = LPC_HOLD;
      else             mode_d = LPC_AUTO;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= LPC_OFF;
      else        mode_q <= mode_d;
   end

   // enables per mode
   always_comb begin
      drv_en_o  = 1'b0;
      rx_en_o   = 1'b0;
      pump_en_o = 1'b0;
      case (mode_q)
         LPC_HOLD: begin
            drv_en_o  = 1'b1;
            rx_en_o   = 1'b1;
            pump_en_o = 1'b1;
         end
         LPC_AUTO: begin
            rx_en_o   = 1'b1;
            pump_en_o = !idle_q;
            drv_en_o  = ready_q && !idle_q;
         end
         default: begin
            drv_en_o  = 1'b0;
            rx_en_o   = 1'b0;
            pump_en_o = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/lpc_chk.sv
// Property checker attached to line_power_ctrl.
module lpc_chk (
   input logic clk,
   input logic rst_n,
   input logic shdn_s,
   input logic hold_s,
   input logic act_s,
   input logic idle_q,
   input logic status_o,
   input logic drv_en_o,
   input logic rx_en_o,
   input logic pump_en_o
);

   // R2
   shutdown_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shdn_s |=> (!drv_en_o && !rx_en_o && !pump_en_o));

   // R3
   hold_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shdn_s && hold_s) |=> (drv_en_o && rx_en_o && pump_en_o));

   // R4
   auto_rx_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shdn_s && !hold_s) |=> rx_en_o);

   // R5
   auto_pump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shdn_s && !hold_s) |=> (pump_en_o == !idle_q));

   // R6
   drv_needs_pump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en_o |-> pump_en_o);

   // R7
   idle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(idle_q) |-> !$past(act_s));

   // R7
   idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_s |=> !idle_q);

   // R8
   status_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(status_o) |-> ($past(act_s) == status_o));

endmodule

bind line_power_ctrl lpc_chk u_lpc_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .shdn_s    (shdn_s),
   .hold_s    (hold_s),
   .act_s     (act_s),
   .idle_q    (idle_q),
   .status_o  (status_o),
   .drv_en_o  (drv_en_o),
   .rx_en_o   (rx_en_o),
   .pump_en_o (pump_en_o)
);

// File: tb/test_line_power_ctrl.sv
module test_line_power_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NRX = 3;
   localparam int SD  = 4;   // status persistence
   localparam int ID  = 10;  // quiet time before standby
   localparam int WD  = 6;   // driver wake delay
   localparam int LAT = 3;   // two sync flops plus one register

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           shdn_n = 1'b0;
   logic           hold_on = 1'b0;
   logic [NRX-1:0] rx_idle = '1;
   logic           status, drv_en, rx_en, pump_en;

   int checks = 0;
   int failures = 0;
   bit model_on = 1'b0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   line_power_ctrl #(
      .N_RX(NRX), .SYNC_STAGES(2), .STATUS_DLY(SD), .IDLE_DLY(ID), .WAKE_DLY(WD)
   ) i_line_power_ctrl (
      .clk(clk), .rst_n(rst_n), .shdn_n_i(shdn_n), .hold_on_i(hold_on),
      .rx_idle_i(rx_idle), .status_o(status), .drv_en_o(drv_en),
      .rx_en_o(rx_en), .pump_en_o(pump_en)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // ---------------- reference model built from the requirements ----------
   logic [NRX+1:0] m_s1, m_s2;
   bit m_st, m_idle, m_rdy;
   int m_srun, m_icnt, m_rcnt, m_mode;  // mode: 0 off, 1 hold, 2 auto

   function automatic bit exp_drv(input int md, input bit rdy, input bit idl);
      return (md == 1) || (md == 2 && rdy && !idl);
   endfunction
   function automatic bit exp_pump(input int md, input bit idl);
      return (md == 1) || (md == 2 && !idl);
   endfunction
   function automatic bit exp_rx(input int md);
      return md != 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = {2'b00, {NRX{1'b1}}};
         m_s2 = m_s1;
         m_st = 0; m_srun = 0;
         m_idle = 1; m_icnt = 0;
         m_rdy = 0; m_rcnt = 0;
         m_mode = 0;
      end else begin
         bit act;
         act = !(&m_s2[NRX-1:0]);
         if (act != m_st) begin
            m_srun++;
            if (m_srun == SD) begin m_st = act; m_srun = 0; end
         end else m_srun = 0;
         if (m_idle) begin m_rdy = 0; m_rcnt = 0; end
         else if (!m_rdy) begin m_rcnt++; if (m_rcnt == WD) m_rdy = 1; end
         if (act) begin m_idle = 0; m_icnt = 0; end
         else if (!m_idle) begin m_icnt++; if (m_icnt == ID) m_idle = 1; end
         m_mode = !m_s2[NRX+1] ? 0 : (m_s2[NRX] ? 1 : 2);
         m_s2 = m_s1;
         m_s1 = {shdn_n, hold_on, rx_idle};
      end
   end

   always @(negedge clk) begin
      if (rst_n && model_on) begin
         chk("R6", "model drv_en", drv_en, exp_drv(m_mode, m_rdy, m_idle));
         chk("R5", "model pump_en", pump_en, exp_pump(m_mode, m_idle));
         chk("R4", "model rx_en", rx_en, exp_rx(m_mode));
         chk("R8", "model status", status, m_st);
      end
   end

   task automatic nstep(input int n);
      repeat (n) @(negedge clk);
   endtask

   // watchdog
   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      nstep(3);
      // R9: reset state
      chk("R9", "reset drv_en", drv_en, 0);
      chk("R9", "reset rx_en", rx_en, 0);
      chk("R9", "reset pump_en", pump_en, 0);
      chk("R9", "reset status", status, 0);
      rst_n = 1'b1;
      model_on = 1'b1;
      nstep(5);
      chk("R9", "post-reset status", status, 0);

      // R1 / R3: hold mode latency with all receivers quiet
      shdn_n = 1; hold_on = 1;
      nstep(LAT - 1);
      chk("R1", "drv_en before sync latency", drv_en, 0);
      nstep(1);
      chk("R3", "hold drv_en with quiet line", drv_en, 1);
      chk("R3", "hold pump_en with quiet line", pump_en, 1);
      chk("R3", "hold rx_en with quiet line", rx_en, 1);

      // R9 / R4: automatic mode starts in standby
      hold_on = 0;
      nstep(LAT);
      chk("R9", "auto starts in standby, drv_en", drv_en, 0);
      chk("R5", "auto standby pump_en", pump_en, 0);
      chk("R4", "auto standby rx_en", rx_en, 1);

      // R5 / R6 / R8: activity returns on receiver 0 (bit 0 = 0 means active)
      rx_idle = 3'b110;
      nstep(2);
      chk("R5", "pump_en one edge early", pump_en, 0);
      nstep(1);
      chk("R5", "pump_en on activity", pump_en, 1);
      chk("R6", "drv_en waits for wake", drv_en, 0);
      nstep(SD - 1);                       // total 2+SD edges
      chk("R8", "status rises after persistence", status, 1);
      nstep(WD - SD);                      // total 2+WD edges
      chk("R6", "drv_en one edge before wake", drv_en, 0);
      nstep(1);
      chk("R6", "drv_en after wake delay", drv_en, 1);

      // R7: standby after exactly ID quiet edges
      rx_idle = 3'b111;
      nstep(ID + 1);
      chk("R7", "pump_en one edge before standby", pump_en, 1);
      nstep(1);
      chk("R7", "pump_en drops at standby", pump_en, 0);
      chk("R6", "drv_en off in standby", drv_en, 0);
      chk("R8", "status low with quiet line", status, 0);

      // R7 / R8: one-cycle pulse restarts the quiet count, not the status
      rx_idle = 3'b101;
      nstep(LAT + WD + 2);
      rx_idle = 3'b111;
      nstep(7);
      rx_idle = 3'b011;
      nstep(1);
      rx_idle = 3'b111;
      nstep(ID);
      chk("R7", "quiet count restarted by pulse", pump_en, 1);
      chk("R8", "short pulse ignored by status", status, 0);
      nstep(4);
      chk("R7", "standby after restarted count", pump_en, 0);

      // R2 / R8: shutdown wins over hold, status still tracks the line
      hold_on = 1; shdn_n = 0; rx_idle = 3'b000;
      nstep(LAT);
      chk("R2", "shutdown drv_en", drv_en, 0);
      chk("R2", "shutdown rx_en", rx_en, 0);
      chk("R2", "shutdown pump_en", pump_en, 0);
      nstep(SD);
      chk("R8", "status during shutdown", status, 1);

      // seeded random sequences checked against the model each cycle
      for (int seg = 0; seg < 500; seg++) begin
         int r;
         r = int'($urandom % 100);
         if (r < 20) begin
            shdn_n  = ($urandom % 5) != 0;
            hold_on = ($urandom % 3) == 0;
         end
         if (($urandom % 2) == 0) rx_idle = '1;
         else                     rx_idle = NRX'($urandom);
         nstep(1 + int'($urandom % 24));
      end

      done = 1'b1;
      model_on = 1'b0;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule